// File: doc/BRIEF.md
# MMU Fault Status Capture

This block holds the fault record of a paging memory-management unit. Each translation fault arrives as a single-cycle strobe. The strobe carries the kind of access, a 3-bit error code produced elsewhere and the virtual address that faulted. The block packs the access kind and error code into a status word and sets an address-valid flag. It also loads the faulting address into a separate address register. If an earlier fault was never read, the status word shows an overflow. One cycle after the fault, the block reports whether the fault raises an instruction-fetch trap, a data trap or no trap at all.

While no-fault mode is active, or while traps are disabled, a fault raises no trap. Instead the access is granted read, write and execute rights, so the surrounding logic can install a forced mapping. A separate combinational output tells the permission checker to skip its check for user-mode accesses while no-fault mode is on. Software reads the status word through a read strobe, and that read clears the word on the next clock.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset, the status word, the address register, `trap_type` and `grant_rwx` are all zero.
- R2: On a fault, status bits 7:5 hold the access index: bit 7 is set for a write, bit 6 for an instruction fetch and bit 5 for a supervisor access.
- R3: On a fault, status bits 4:2 hold the error code and bit 1, the address-valid flag, is set.
- R4: If the status word is nonzero and is not being read when a new fault arrives, it is first reduced to 1 and then combined with the new fields. The result has bit 0 (overflow) set and the earlier error and access bits discarded.
- R5: A read strobe with no fault in the same cycle clears the status word to zero on the next clock.
- R6: When a read strobe and a fault arrive in the same cycle, the status word takes only the new fault's fields, with no overflow mark.
- R7: Every fault loads the full virtual address into the address register, replacing the previous value.
- R8: One cycle after a fault that raises a trap, `trap_type` is 2'b01 for an instruction fetch or 2'b10 for a load or store, and it stays there for one cycle only. At all other times it is 2'b00.
- R9: One cycle after a fault taken with no-fault mode on or traps disabled, `trap_type` is 2'b00 and `grant_rwx` is 1 for one cycle. `grant_rwx` stays 0 after a fault that raises a trap.
- R10: `check_bypass` is 1 exactly when no-fault mode is on and the access is a user access (the supervisor bit is clear), whether or not a fault is present.
- R11: With no fault and no read, the status word and the address register hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault strobe, one cycle per fault |
| flt_write | input | 1 | The access is a write |
| flt_fetch | input | 1 | The access is an instruction fetch |
| flt_super | input | 1 | The access is made in supervisor mode |
| flt_err | input | ERR_W (3) | Error code from the permission check |
| flt_vaddr | input | VA_W (32) | Faulting virtual address |
| nofault_mode | input | 1 | No-fault mode is enabled |
| traps_en | input | 1 | Traps are enabled |
| stat_rd | input | 1 | Read strobe for the status word (clears it) |
| stat_q | output | STAT_W (32) | Status word |
| addr_q | output | VA_W (32) | Fault address register |
| trap_type | output | 2 | 00 none, 01 instruction fault, 10 data fault |
| grant_rwx | output | 1 | Forced read/write/execute grant in place of a trap |
| check_bypass | output | 1 | Skip the permission check for this user access |

## Verification
The bench sends a second fault while the first is still unread and expects the word to collapse to 1 and then take the new fields. A design that kept the old fields, or that never marked overflow, shows extra or missing bits. It also sends a read and a fault in the same cycle, where a design that checked the stale word would set overflow by mistake. No-fault mode and disabled traps are each tried separately, which catches a design that still raises a trap or drops the grant. The bench also checks that the trap pulse lasts only one cycle and that a plain read clears the word.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
   typedef enum logic [1:0] {
      TRAP_NONE = 2'b00,
      TRAP_INSN = 2'b01,
      TRAP_DATA = 2'b10
   } trap_t;

   localparam int ACC_BITS = 3;
endpackage

// File: rtl/mfc_status_reg.sv
module mfc_status_reg #(
   parameter int STAT_W = 32,
   parameter int ERR_W  = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flt_valid,
   input  logic [mfc_pkg::ACC_BITS-1:0] acc_idx,
   input  logic [ERR_W-1:0]             err,
   input  logic                         rd,
   output logic [STAT_W-1:0]            stat_q
);
   localparam int ERR_LSB = 2;
   localparam int ACC_LSB = ERR_LSB + ERR_W;
   localparam int USED_W  = ACC_LSB + mfc_pkg::ACC_BITS;

   if (STAT_W < USED_W) begin : g_width_bad
      $error("STAT_W too small for status fields");
   end

   logic [STAT_W-1:0] base, fresh, nxt;

   always_comb begin
      // an unread nonzero word collapses to the overflow mark
      base = '0;
      if (stat_q != '0 && !rd) base[0] = 1'b1;
      fresh = '0;
      fresh[1] = 1'b1;
      fresh[ERR_LSB +: ERR_W] = err;
      fresh[ACC_LSB +: mfc_pkg::ACC_BITS] = acc_idx;
      if (flt_valid)  nxt = base | fresh;
      else if (rd)    nxt = '0;
      else            nxt = stat_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= nxt;
   end

   // R3
   valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid |=> stat_q[1]);
   // R4
   overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && !rd && stat_q != '0) |=> stat_q[0]);
   // R6
   rd_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && rd) |=> !stat_q[0]);
   // R5
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !flt_valid) |=> stat_q == '0);
   // R11
   stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd && !flt_valid) |=> $stable(stat_q));
endmodule

// File: rtl/mfc_addr_reg.sv
module mfc_addr_reg #(
   parameter int VA_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [VA_W-1:0] vaddr,
   output logic [VA_W-1:0] addr_q
);
   if (VA_W < 1) begin : g_width_bad
      $error("VA_W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= vaddr;
   end

   // R7
   addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> addr_q == $past(vaddr));
   // R11
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(addr_q));
endmodule

// File: rtl/mfc_trap_sel.sv
module mfc_trap_sel #(
   parameter bit TRAP_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flt_valid,
   input  logic           is_fetch,
   input  logic           suppress,
   output mfc_pkg::trap_t trap_type,
   output logic           grant_rwx
);
   import mfc_pkg::*;

   trap_t sel_d;
   logic  grant_d;

   always_comb begin
      sel_d   = TRAP_NONE;
      grant_d = 1'b0;
      if (flt_valid) begin
         if (suppress)      grant_d = 1'b1;
         else if (is_fetch) sel_d   = TRAP_INSN;
         else               sel_d   = TRAP_DATA;
      end
   end

   if (TRAP_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            trap_type <= TRAP_NONE;
            grant_rwx <= 1'b0;
         end else begin
            trap_type <= sel_d;
            grant_rwx <= grant_d;
         end
      end
      // R9
      suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flt_valid && suppress) |=> (trap_type == TRAP_NONE) && grant_rwx);
      // R8
      trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !flt_valid |=> trap_type == TRAP_NONE);
   end else begin : g_comb
      assign trap_type = sel_d;
      assign grant_rwx = grant_d;
   end

   // R8
   trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(trap_type));
   // R9
   grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_rwx |-> trap_type == TRAP_NONE);
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture #(
   parameter int STAT_W   = 32,
   parameter int ERR_W    = 3,
   parameter int VA_W     = 32,
   parameter bit TRAP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flt_valid,
   input  logic              flt_write,
   input  logic              flt_fetch,
   input  logic              flt_super,
   input  logic [ERR_W-1:0]  flt_err,
   input  logic [VA_W-1:0]   flt_vaddr,
   input  logic              nofault_mode,
   input  logic              traps_en,
   input  logic              stat_rd,
   output logic [STAT_W-1:0] stat_q,
   output logic [VA_W-1:0]   addr_q,
   output logic [1:0]        trap_type,
   output logic              grant_rwx,
   output logic              check_bypass
);
   import mfc_pkg::*;

   logic [ACC_BITS-1:0] acc_idx;
   logic                suppress;
   trap_t               trap_e;

   assign acc_idx      = {flt_write, flt_fetch, flt_super};
   assign suppress     = nofault_mode || !traps_en;
   assign check_bypass = nofault_mode && !flt_super;
   assign trap_type    = trap_e;

   mfc_status_reg #(.STAT_W(STAT_W), .ERR_W(ERR_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .acc_idx(acc_idx),
      .err(flt_err), .rd(stat_rd), .stat_q(stat_q));

   mfc_addr_reg #(.VA_W(VA_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(flt_valid), .vaddr(flt_vaddr),
      .addr_q(addr_q));

   mfc_trap_sel #(.TRAP_REG(TRAP_REG)) u_trap (
      .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .is_fetch(flt_fetch),
      .suppress(suppress), .trap_type(trap_e), .grant_rwx(grant_rwx));
endmodule

// File: tb/mmu_fault_capture_test.sv
module mmu_fault_capture_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flt_valid = 0, flt_write = 0, flt_fetch = 0, flt_super = 0;
   logic [2:0]  flt_err = '0;
   logic [31:0] flt_vaddr = '0;
   logic        nofault_mode = 0, traps_en = 1, stat_rd = 0;
   logic [31:0] stat_q, addr_q;
   logic [1:0]  trap_type;
   logic        grant_rwx, check_bypass;

   int tests = 0, fails = 0;
   logic [31:0] exp_stat = '0;
   logic [31:0] exp_addr = '0;

   always #2 clk = ~clk;

   mmu_fault_capture uut (
      .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_write(flt_write),
      .flt_fetch(flt_fetch), .flt_super(flt_super), .flt_err(flt_err),
      .flt_vaddr(flt_vaddr), .nofault_mode(nofault_mode), .traps_en(traps_en),
      .stat_rd(stat_rd), .stat_q(stat_q), .addr_q(addr_q),
      .trap_type(trap_type), .grant_rwx(grant_rwx), .check_bypass(check_bypass));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle of stimulus, applied at negedge, outputs sampled at next negedge
   task automatic step(input logic v, input logic w, input logic f, input logic s,
                       input logic [2:0] e, input logic [31:0] va,
                       input logic nf, input logic te, input logic rd);
      logic [31:0] base;
      flt_valid = v; flt_write = w; flt_fetch = f; flt_super = s;
      flt_err = e; flt_vaddr = va; nofault_mode = nf; traps_en = te; stat_rd = rd;
      base = (exp_stat != 0 && !rd) ? 32'd1 : 32'd0;
      if (v) begin
         exp_stat = base | ({29'd0, w, f, s} << 5) | ({29'd0, e} << 2) | 32'd2;
         exp_addr = va;
      end else if (rd) exp_stat = '0;
      @(posedge clk);
      @(negedge clk);
      flt_valid = 0; stat_rd = 0;
   endtask

   task automatic t_reset();
      chk("R1 status", stat_q, 0);
      chk("R1 addr", addr_q, 0);
      chk("R1 trap", {30'd0, trap_type}, 0);
      chk("R1 grant", {31'd0, grant_rwx}, 0);
   endtask

   task automatic t_data_fault();
      step(1, 0, 0, 0, 3'd3, 32'h1234_5678, 0, 1, 0);
      chk("R3 status", stat_q, 32'h0E);
      chk("R3 expected model", exp_stat, 32'h0E);
      chk("R7 addr", addr_q, 32'h1234_5678);
      chk("R8 data trap", {30'd0, trap_type}, 2);
      chk("R9 no grant", {31'd0, grant_rwx}, 0);
   endtask

   task automatic t_overflow();
      step(1, 0, 1, 1, 3'd5, 32'hDEAD_B000, 0, 1, 0);
      chk("R4 overflow", stat_q, 32'h77);
      chk("R2 fetch+super", stat_q[7:5], 3'b011);
      chk("R8 insn trap", {30'd0, trap_type}, 1);
      chk("R7 addr replaced", addr_q, 32'hDEAD_B000);
      step(0, 0, 0, 0, 3'd0, 32'hFFFF_FFFF, 0, 1, 0);
      chk("R8 pulse ends", {30'd0, trap_type}, 0);
      chk("R11 status hold", stat_q, 32'h77);
      chk("R11 addr hold", addr_q, 32'hDEAD_B000);
   endtask

   task automatic t_read_clear();
      step(0, 0, 0, 0, 3'd0, 32'h0, 0, 1, 1);
      chk("R5 cleared", stat_q, 0);
   endtask

   task automatic t_nofault();
      step(1, 1, 0, 1, 3'd1, 32'h0000_4000, 1, 1, 0);
      chk("R2 write+super", stat_q, 32'hA6);
      chk("R9 nofault no trap", {30'd0, trap_type}, 0);
      chk("R9 nofault grant", {31'd0, grant_rwx}, 1);
   endtask

   task automatic t_rd_and_fault();
      step(1, 1, 0, 0, 3'd2, 32'h8000_0004, 0, 0, 1);
      chk("R6 no overflow", stat_q, 32'h8A);
      chk("R9 traps off no trap", {30'd0, trap_type}, 0);
      chk("R9 traps off grant", {31'd0, grant_rwx}, 1);
      step(0, 0, 0, 0, 3'd0, 32'h0, 0, 1, 0);
      chk("R9 grant one cycle", {31'd0, grant_rwx}, 0);
   endtask

   task automatic t_bypass();
      nofault_mode = 1; flt_super = 0; #1;
      chk("R10 nf user", {31'd0, check_bypass}, 1);
      flt_super = 1; #1;
      chk("R10 nf super", {31'd0, check_bypass}, 0);
      nofault_mode = 0; flt_super = 0; #1;
      chk("R10 normal user", {31'd0, check_bypass}, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_data_fault();
      t_overflow();
      t_read_clear();
      t_nofault();
      t_rd_and_fault();
      t_bypass();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule